// File: doc/BRIEF.md
# Bit-Sliced Integer ALU

A purely combinational integer ALU whose datapath is a chain of identical one-bit cells. Each cell holds an AND gate, an OR gate, a full adder and a comparison input. The cell at the sign position is a variant that also derives the overflow flag and the comparison outcome. The cells share a two-bit function select and a B-invert control. The carry-in feeds the low cell, and each cell's carry-out feeds the next cell up.

Subtraction needs no subtractor. The caller sets B-invert and drives carry-in high, so the adder computes A + ~B + 1. The set-if-less function runs that same subtraction internally. The sign cell's comparison outcome is routed back to the comparison input of bit 0, and every other bit of the result is forced to zero. A separate control selects signed or unsigned comparison. The block has no clock and no state. Every output follows the inputs within the same evaluation, and no handshake is involved.

Top module: `bitslice_alu`

## Requirements
- R1: With op_sel = 0, result is the bitwise AND of a_in and the effective B operand. The effective B operand is ~b_in when b_invert = 1 and b_in otherwise.
- R2: With op_sel = 1, result is the bitwise OR of a_in and the effective B operand.
- R3: With op_sel = 2 and b_invert = 0, {carry_out, result} equals a_in + b_in + carry_in taken as 33-bit unsigned.
- R4: With op_sel = 2, b_invert = 1 and carry_in = 1, result equals a_in - b_in modulo 2^32. In this mode carry_out is 1 exactly when a_in >= b_in unsigned.
- R5: With op_sel = 2, overflow is 1 exactly when the carry into bit 31 differs from the carry out of bit 31. Equivalently, both addend signs agree and the sum sign differs from them, so a carry-out alone never raises it.
- R6: overflow reads 0 for op_sel 0, 1 and 3. carry_out reads 0 for op_sel 0 and 1.
- R7: With op_sel = 3, b_invert = 1, carry_in = 1 and unsigned_cmp = 0, result is 1 when a_in < b_in as signed two's-complement values and 0 otherwise. This holds even when the internal subtraction overflows, for example with 0x80000000 as an operand.
- R8: Under the same settings as R7 but with unsigned_cmp = 1, result is 1 when a_in < b_in as unsigned values. For example, 0xFFFFFFFE is less than 0x000014A0 signed but not unsigned.
- R9: With op_sel = 3, result bits 31 down to 1 are always 0.
- R10: zero is 1 exactly when all 32 result bits are 0, for every operation.
- R11: unsigned_cmp has no effect on result, carry_out or overflow for op_sel 0, 1 and 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | 32 | First operand |
| b_in | input | 32 | Second operand |
| b_invert | input | 1 | Inverts every bit of the second operand before use |
| carry_in | input | 1 | Carry into bit 0 |
| op_sel | input | 2 | 0 AND, 1 OR, 2 add, 3 set-if-less |
| unsigned_cmp | input | 1 | Selects an unsigned comparison for op_sel 3 |
| result | output | 32 | Operation result |
| zero | output | 1 | High when result is all zeros |
| carry_out | output | 1 | Carry out of bit 31 for op_sel 2 and 3 |
| overflow | output | 1 | Signed overflow for op_sel 2 |

## Verification
The bench builds the block at its default width of 32, so the exact operand values that exercise the sign cell can be driven directly. These include 0x80000000, whose negation is itself, 0x7FFFFFFF and the all-ones word. At that width, overflow in add and subtract, signed and unsigned comparison across the sign boundary, and carry-out without overflow are all reached by directed vectors. Random operands, biased toward those edge words, then cover every function select with both values of B-invert and carry-in.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [1:0] {
    OP_AND  = 2'd0,
    OP_OR   = 2'd1,
    OP_ADD  = 2'd2,
    OP_LESS = 2'd3
  } alu_op_e;
endpackage

// File: rtl/alu_slice.sv
module alu_slice
  import alu_pkg::*;
#(
  parameter bit IS_MSB = 1'b0
) (
  input  logic    a_bit,
  input  logic    b_bit,
  input  logic    b_inv,
  input  logic    c_in,
  input  logic    less_in,
  input  logic    uns_cmp,
  input  alu_op_e op,
  output logic    res_bit,
  output logic    c_out,
  output logic    set_out,
  output logic    ovf_out
);
  logic b_eff, prop, gen, sum_bit;

  always_comb begin
    b_eff   = b_bit ^ b_inv;
    prop    = a_bit ^ b_eff;
    gen     = a_bit & b_eff;
    sum_bit = prop ^ c_in;
    c_out   = gen | (prop & c_in);
    unique case (op)
      OP_AND:  res_bit = a_bit & b_eff;
      OP_OR:   res_bit = a_bit | b_eff;
      OP_ADD:  res_bit = sum_bit;
      default: res_bit = less_in;
    endcase
  end

  generate
    if (IS_MSB) begin : g_sign
      logic ovf_raw;
      always_comb begin
        ovf_raw = c_in ^ c_out;
        ovf_out = ovf_raw;
        set_out = uns_cmp ? ~c_out : (sum_bit ^ ovf_raw);
      end
      // Sign rule cross-check of the carry-based overflow.
      always_comb begin
        assert_sign_rule_R5: assert (ovf_raw == ((a_bit == b_eff) && (sum_bit != a_bit)))
          else $error("sign-cell overflow disagrees with sign rule");
      end
    end else begin : g_plain
      always_comb begin
        ovf_out = 1'b0;
        set_out = 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/alu_zero_detect.sv
module alu_zero_detect #(
  parameter int W = 32
) (
  input  logic [W-1:0] value,
  output logic         all_zero
);
  localparam int HALF = W / 2;
  logic lo_any, hi_any;

  always_comb begin
    lo_any   = |value[HALF-1:0];
    hi_any   = |value[W-1:HALF];
    all_zero = ~(lo_any | hi_any);
  end
endmodule

// File: rtl/bitslice_alu.sv
module bitslice_alu
  import alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         b_invert,
  input  logic         carry_in,
  input  logic [1:0]   op_sel,
  input  logic         unsigned_cmp,
  output logic [W-1:0] result,
  output logic         zero,
  output logic         carry_out,
  output logic         overflow
);
  localparam int MSB = W - 1;

  alu_op_e      op;
  logic         chain [W+1];
  logic [W-1:0] set_vec, ovf_vec, less_vec, res_vec;
  logic         set_fb, ovf_msb, zero_w;

  assign op       = alu_op_e'(op_sel);
  assign chain[0] = carry_in;
  assign set_fb   = |set_vec;
  assign ovf_msb  = |ovf_vec;

  always_comb begin
    less_vec    = '0;
    less_vec[0] = set_fb;
  end

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_cell
      alu_slice #(.IS_MSB(i == MSB)) u_cell (
        .a_bit   (a_in[i]),
        .b_bit   (b_in[i]),
        .b_inv   (b_invert),
        .c_in    (chain[i]),
        .less_in (less_vec[i]),
        .uns_cmp (unsigned_cmp),
        .op      (op),
        .res_bit (res_vec[i]),
        .c_out   (chain[i+1]),
        .set_out (set_vec[i]),
        .ovf_out (ovf_vec[i])
      );
    end
  endgenerate

  alu_zero_detect #(.W(W)) u_zero (
    .value    (res_vec),
    .all_zero (zero_w)
  );

  always_comb begin
    result    = res_vec;
    zero      = zero_w;
    carry_out = (op == OP_ADD || op == OP_LESS) ? chain[W] : 1'b0;
    overflow  = (op == OP_ADD) ? ovf_msb : 1'b0;
  end

  // Checks beside the result mux and flag gating.
  logic [W:0]   wide_sum;
  logic [W-1:0] b_eff_w;
  always_comb begin
    b_eff_w  = b_invert ? ~b_in : b_in;
    wide_sum = {1'b0, a_in} + {1'b0, b_eff_w} + {{W{1'b0}}, carry_in};
    if (op == OP_ADD) begin
      assert_sum_R3: assert ({carry_out, result} == wide_sum)
        else $error("adder output mismatch");
    end
    if (op == OP_AND || op == OP_OR) begin
      assert_logic_flags_R6: assert (!overflow && !carry_out)
        else $error("flags raised for logic op");
    end
    if (op == OP_LESS) begin
      assert_less_upper_R9: assert (result[W-1:1] == '0)
        else $error("upper bits set in compare");
      if (b_invert && carry_in && !unsigned_cmp) begin
        assert_signed_less_R7: assert (result[0] == ($signed(a_in) < $signed(b_in)))
          else $error("signed compare wrong");
      end
      if (b_invert && carry_in && unsigned_cmp) begin
        assert_unsigned_less_R8: assert (result[0] == (a_in < b_in))
          else $error("unsigned compare wrong");
      end
    end
    assert_zero_flag_R10: assert (zero == (result == '0))
      else $error("zero flag mismatch");
  end
endmodule

// File: tb/bitslice_alu_bench.sv
module bitslice_alu_bench;
  localparam int W = 32;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [W-1:0] a, b, res;
  logic binv, cin, uns, zf, cout, ovf;
  logic [1:0] op;
  int checks = 0, fails = 0;
  bit done = 0;

  bitslice_alu #(.W(W)) u_bitslice_alu (
    .a_in(a), .b_in(b), .b_invert(binv), .carry_in(cin), .op_sel(op),
    .unsigned_cmp(uns), .result(res), .zero(zf), .carry_out(cout), .overflow(ovf)
  );

  function automatic logic [W+2:0] model(input logic [W-1:0] x, input logic [W-1:0] y,
                                          input logic bi, input logic ci,
                                          input logic [1:0] o, input logic u);
    logic [W-1:0] ye, r;
    logic [W:0] s;
    logic c, v;
    ye = bi ? ~y : y;
    s  = {1'b0, x} + {1'b0, ye} + {{W{1'b0}}, ci};
    c = 1'b0; v = 1'b0;
    case (o)
      2'd0: r = x & ye;
      2'd1: r = x | ye;
      2'd2: begin
        r = s[W-1:0]; c = s[W];
        v = (x[W-1] == ye[W-1]) && (s[W-1] != x[W-1]);
      end
      default: begin
        c = s[W];
        r = '0;
        r[0] = u ? (x < y) : ($signed(x) < $signed(y));
      end
    endcase
    return {r, (r == '0), c, v};
  endfunction

  function automatic string tag(input logic [1:0] o, input logic bi, input logic u);
    case (o)
      2'd0: return "R1";
      2'd1: return "R2";
      2'd2: return bi ? "R4" : "R3";
      default: return u ? "R8" : "R7";
    endcase
  endfunction

  task automatic chk(input string r, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic run(input logic [W-1:0] x, input logic [W-1:0] y, input logic bi,
                     input logic ci, input logic [1:0] o, input logic u);
    logic [W+2:0] e;
    @(posedge clk);
    a = x; b = y; binv = bi; cin = ci; op = o; uns = u;
    e = model(x, y, bi, ci, o, u);
    @(negedge clk);
    chk(tag(o, bi, u), res, e[W+2:3]);
    chk("R10", {{(W-1){1'b0}}, zf}, {{(W-1){1'b0}}, e[2]});
    chk((o < 2) ? "R6" : tag(o, bi, u), {{(W-1){1'b0}}, cout}, {{(W-1){1'b0}}, e[1]});
    chk((o == 2) ? "R5" : "R6", {{(W-1){1'b0}}, ovf}, {{(W-1){1'b0}}, e[0]});
    if (o == 2'd3) chk("R9", {1'b0, res[W-1:1]}, '0);
  endtask

  function automatic logic [W-1:0] pick();
    case ($urandom % 8)
      0: return 32'h8000_0000;
      1: return 32'h7FFF_FFFF;
      2: return 32'hFFFF_FFFF;
      3: return 32'h0;
      4: return 32'h1;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    #3_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    a = '0; b = '0; binv = 0; cin = 0; op = 0; uns = 0;
    @(negedge clk);
    chk("R10", {{(W-1){1'b0}}, zf}, 1);        // idle inputs: AND of zeros
    chk("R1", res, '0);
    // directed corners
    run(32'hFFFF_FFFE, 32'h0000_14A0, 1, 1, 3, 0);  // R7 signed: 1
    run(32'hFFFF_FFFE, 32'h0000_14A0, 1, 1, 3, 1);  // R8 unsigned: 0
    run(32'h7FFF_FFFF, 32'h8000_0000, 1, 1, 3, 0);  // R7 with overflowing subtract
    run(32'h8000_0000, 32'h7FFF_FFFF, 1, 1, 3, 0);
    run(32'h0, 32'h8000_0000, 1, 1, 2, 0);          // R4/R5 negate min value
    run(32'h8000_0000, 32'h8000_0000, 1, 1, 2, 0);  // R4 zero, no overflow
    run(32'h8000_0000, 32'h1, 1, 1, 2, 0);          // R5 overflow on subtract
    run(32'h8000_0000, 32'h8000_0000, 0, 0, 2, 0);  // R5 both carry and overflow
    run(32'hFFFF_FFFF, 32'h1, 0, 0, 2, 0);          // R5 carry without overflow
    run(32'hF0F0_F0F0, 32'h0FF0_0FF0, 1, 0, 0, 1);  // R1 with inverted B
    run(32'h0, 32'h0, 1, 0, 1, 0);                  // R2 inverted B all ones
    run(32'h1234_5678, 32'h1234_5678, 1, 1, 2, 1);  // R11 uns ignored, R10 zero
    for (int k = 0; k < 3000; k++) begin
      logic [1:0] o;
      o = 2'($urandom % 4);
      if (o == 2'd3) run(pick(), pick(), 1, 1, o, 1'($urandom));
      else run(pick(), pick(), 1'($urandom), 1'($urandom), o, 1'($urandom)); // R11
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule